// File: doc/BRIEF.md
# Dual Transfer Buffer Host Port

This block holds two 64-word transfer buffers, each word 64 bits wide, for single-block card traffic. A host reaches them through two registers: an index register that names a buffer, a starting word and whether accesses step forward, and a 64-bit data register whose writes store into the named word and whose reads return it one cycle later. With stepping enabled, each data access moves the word offset on by one and wraps inside the same buffer.

The card side is a pair of byte streams with valid/ready handshakes. A transfer is armed with a buffer number, a direction and a byte count N. N must be a multiple of 8 from 8 to 512. The first word used sits at offset 64 − N/8, so a short block always ends at the last word. In the fill direction (card to buffer, a read), the block accepts bytes on `fill_*` and packs them into words, first byte in the top lane. In the drain direction (buffer to card, a write), it presents stored words on `drain_*` one byte at a time, top lane first. Back-pressure rules: a fill byte moves on a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` drops while a packed word waits for the buffer. Once `drain_valid` is high, `drain_data` holds still until `drain_ready` takes it. When a transfer ends, a one-cycle done pulse is given along with the buffer number and the direction code.

Both sides share one single-port RAM. A host data access always wins the port in its cycle, and the card side waits.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset `idx_q` is 0, and `rd_valid`, `xfer_busy`, `fill_ready`, `drain_valid`, `buf_done` and `done_type` are all 0.
- R2: A write to the index register stores all 17 bits, and `idx_q` returns them. Bit 16 enables stepping, bit 6 selects buffer 0 or 1, and bits 5:0 give the word offset.
- R3: `dat_wr` stores `dat_wdata` at the selected buffer and word. `dat_rd` makes `rd_valid` high in the next cycle, with that word on `rd_data`.
- R4: With bit 16 set, each data access adds one to the offset field, wrapping from 63 to 0. The buffer bit does not change.
- R5: With bit 16 clear, repeated data accesses use the same word, and `idx_q` does not change.
- R6: If an index write and a data access occur in the same cycle, the access uses the old index. The written value is then loaded as given, with no step.
- R7: `xfer_start` is accepted only when idle and when N is a nonzero multiple of 8 no larger than 512. Any other start is ignored and leaves `xfer_busy` low or unchanged. The first word used is at offset 64 − N/8.
- R8: In the fill direction (`xfer_dir`=0), byte k of each group of eight lands in bits 63−8k down to 56−8k of its word.
- R9: In the drain direction (`xfer_dir`=1), the bytes of each word are sent from bits 63:56 downward. `drain_data` stays stable while `drain_valid` is high and `drain_ready` is low.
- R10: In any cycle with a host data access, the host gets the RAM. A pending card word write or read waits for a cycle with no host access.
- R11: `buf_done` pulses for one cycle when the last fill word is stored or the last drain byte is taken. `done_buf` gives the buffer, and `done_type` gives 1 for fill (read) or 2 for drain (write). Both hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_wr | input | 1 | Index register write strobe |
| idx_wdata | input | 17 | Index value: bit 16 step enable, bit 6 buffer, bits 5:0 word |
| idx_q | output | 17 | Current index register value |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 64 | Word to store |
| dat_rd | input | 1 | Data register read strobe |
| rd_valid | output | 1 | Read word valid, one cycle after `dat_rd` |
| rd_data | output | 64 | Read word |
| xfer_start | input | 1 | Arm a card-side transfer |
| xfer_dir | input | 1 | 0 fill (card to buffer), 1 drain (buffer to card) |
| xfer_buf | input | 1 | Buffer used by the transfer |
| xfer_bytes | input | 10 | Transfer length N in bytes |
| xfer_busy | output | 1 | Transfer in progress |
| fill_valid | input | 1 | Fill byte valid |
| fill_ready | output | 1 | Fill byte accepted this cycle when valid |
| fill_data | input | 8 | Fill byte |
| drain_valid | output | 1 | Drain byte valid |
| drain_ready | input | 1 | Card takes the drain byte |
| drain_data | output | 8 | Drain byte |
| buf_done | output | 1 | One-cycle completion pulse |
| done_buf | output | 1 | Buffer of the last completed transfer |
| done_type | output | 2 | 1 fill (read), 2 drain (write) |

## Verification
The host port is exercised with a full 64-word stepped sweep, which shows the wrap and whether the buffer bit is kept. Fixed-index repeats separate stepping from non-stepping. An index write that lands in the same cycle as a read shows which index value the read uses. Card transfers are run at full length, at two words and at one word. The full-length run shows the packing order. The short runs show where the start offset falls. A drain under periodic `drain_ready` gaps checks the byte order and that the byte is held during a stall. A run of host reads issued right after a fill's last byte shows that the stored word, and so the done pulse, waits for the host to let go. Starts that arrive while busy or that carry a bad length must leave the running transfer alone.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    XT_NONE  = 2'd0,
    XT_READ  = 2'd1,
    XT_WRITE = 2'd2,
    XT_RSVD  = 2'd3
  } xfer_type_e;
endpackage

// File: rtl/dbp_ram.sv
module dbp_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 64,
  parameter int unsigned AW    = 7
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      else    rdata       <= store[addr];
    end
  end
endmodule

// File: rtl/dbp_index.sv
module dbp_index #(
  parameter int unsigned OFF_W    = 6,
  parameter int unsigned BUF_W    = 1,
  parameter int unsigned AINC_BIT = 16,
  parameter int unsigned IDX_W    = AINC_BIT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             step,
  output logic [BUF_W-1:0] buf_sel,
  output logic [OFF_W-1:0] word_off,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] idx_r;
  logic             ainc;

  assign ainc     = idx_r[AINC_BIT];
  assign buf_sel  = idx_r[OFF_W +: BUF_W];
  assign word_off = idx_r[OFF_W-1:0];
  assign idx_q    = idx_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_r <= '0;
    end else if (idx_wr) begin
      idx_r <= idx_wdata;
    end else if (step && ainc) begin
      idx_r[OFF_W-1:0] <= idx_r[OFF_W-1:0] + 1'b1;
    end
  end

  // R4: stepping advances the offset by one with wrap, buffer kept
  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_wr && ainc) |=> (word_off == OFF_W'($past(word_off) + 1'b1)) && $stable(buf_sel));

  // R5: without stepping the index holds across data accesses
  assert_hold_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_wr && !ainc) |=> $stable(idx_q));
endmodule

// File: rtl/dbp_card.sv
module dbp_card
  import dbp_pkg::*;
#(
  parameter int unsigned OFF_W   = 6,
  parameter int unsigned BUF_W   = 1,
  parameter int unsigned DW      = 64,
  parameter int unsigned BYTES_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xfer_start,
  input  logic                   xfer_dir,
  input  logic [BUF_W-1:0]       xfer_buf,
  input  logic [BYTES_W-1:0]     xfer_bytes,
  output logic                   busy,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [BYTE_W-1:0]      fill_data,
  output logic                   drain_valid,
  input  logic                   drain_ready,
  output logic [BYTE_W-1:0]      drain_data,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [BUF_W+OFF_W-1:0] mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_gnt,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   buf_done,
  output logic [BUF_W-1:0]       done_buf,
  output logic [1:0]             done_type
);
  localparam int unsigned WORDS  = 1 << OFF_W;
  localparam int unsigned BPW    = DW / BYTE_W;
  localparam int unsigned LANE_W = $clog2(BPW);
  localparam int unsigned CNT_W  = OFF_W + 1;

  logic              dir;
  logic [BUF_W-1:0]  bsel;
  logic [OFF_W-1:0]  ptr;
  logic [CNT_W-1:0]  left;
  logic [LANE_W-1:0] lane;
  logic [DW-1:0]     asm_w;
  logic [DW-1:0]     shreg;
  logic              pend, inflight, have;
  xfer_type_e        dtype;

  logic [CNT_W-1:0]  start_words;
  logic [OFF_W-1:0]  start_off;
  logic              start_ok, fill_fire, drain_fire, last_lane;

  assign start_words = xfer_bytes[BYTES_W-1:LANE_W];
  assign start_off   = OFF_W'(CNT_W'(WORDS) - start_words);
  assign start_ok    = !busy && xfer_start && (start_words != '0) &&
                       (start_words <= CNT_W'(WORDS)) && (xfer_bytes[LANE_W-1:0] == '0);

  assign fill_ready  = busy && !dir && !pend;
  assign fill_fire   = fill_valid && fill_ready;
  assign drain_valid = have;
  assign drain_data  = shreg[DW-1 -: BYTE_W];
  assign drain_fire  = drain_valid && drain_ready;
  assign last_lane   = (lane == LANE_W'(BPW - 1));

  assign mem_req   = busy && (dir ? (!have && !inflight && (left != '0)) : pend);
  assign mem_we    = !dir;
  assign mem_addr  = {bsel, ptr};
  assign mem_wdata = asm_w;
  assign done_type = dtype;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir <= 1'b0; bsel <= '0; ptr <= '0; left <= '0; lane <= '0;
      asm_w <= '0; shreg <= '0; pend <= 1'b0; inflight <= 1'b0; have <= 1'b0;
      buf_done <= 1'b0; done_buf <= '0; dtype <= XT_NONE;
    end else begin
      buf_done <= 1'b0;
      if (start_ok) begin
        busy <= 1'b1; dir <= xfer_dir; bsel <= xfer_buf; ptr <= start_off;
        left <= start_words; lane <= '0; pend <= 1'b0; inflight <= 1'b0; have <= 1'b0;
      end
      if (fill_fire) begin
        asm_w[BYTE_W*(BPW-1-int'(lane)) +: BYTE_W] <= fill_data;
        lane <= lane + 1'b1;
        if (last_lane) pend <= 1'b1;
      end
      if (mem_gnt) begin
        ptr  <= ptr + 1'b1;
        left <= left - 1'b1;
        if (!dir) begin
          pend <= 1'b0;
          if (left == CNT_W'(1)) begin
            busy <= 1'b0; buf_done <= 1'b1; done_buf <= bsel; dtype <= XT_READ;
          end
        end else begin
          inflight <= 1'b1;
        end
      end
      if (inflight) begin
        shreg <= mem_rdata; have <= 1'b1; inflight <= 1'b0; lane <= '0;
      end
      if (drain_fire) begin
        shreg <= shreg << BYTE_W;
        lane  <= lane + 1'b1;
        if (last_lane) begin
          have <= 1'b0;
          if (left == '0) begin
            busy <= 1'b0; buf_done <= 1'b1; done_buf <= bsel; dtype <= XT_WRITE;
          end
        end
      end
    end
  end

  // R9: a stalled drain byte is held
  assert_drain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=> drain_valid && $stable(drain_data));

  // R10: a card request that loses arbitration stays raised
  assert_req_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req);

  // R11: completion code is legal and the pulse lasts one cycle
  assert_done_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> (done_type == XT_READ || done_type == XT_WRITE));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !buf_done);
endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port
  import dbp_pkg::*;
#(
  parameter int unsigned NBUF     = 2,
  parameter int unsigned WORDS    = 64,
  parameter int unsigned DW       = 64,
  parameter int unsigned AINC_BIT = 16,
  localparam int unsigned OFF_W   = $clog2(WORDS),
  localparam int unsigned BUF_W   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int unsigned IDX_W   = AINC_BIT + 1,
  localparam int unsigned BYTES_W = OFF_W + 1 + $clog2(DW / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_wr,
  input  logic [IDX_W-1:0]   idx_wdata,
  output logic [IDX_W-1:0]   idx_q,
  input  logic               dat_wr,
  input  logic [DW-1:0]      dat_wdata,
  input  logic               dat_rd,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  input  logic               xfer_start,
  input  logic               xfer_dir,
  input  logic [BUF_W-1:0]   xfer_buf,
  input  logic [BYTES_W-1:0] xfer_bytes,
  output logic               xfer_busy,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [7:0]         fill_data,
  output logic               drain_valid,
  input  logic               drain_ready,
  output logic [7:0]         drain_data,
  output logic               buf_done,
  output logic [BUF_W-1:0]   done_buf,
  output logic [1:0]         done_type
);
  localparam int unsigned AW    = BUF_W + OFF_W;
  localparam int unsigned DEPTH = NBUF * WORDS;

  logic [BUF_W-1:0] buf_sel;
  logic [OFF_W-1:0] word_off;
  logic             host_acc, card_req, card_we, card_gnt;
  logic [AW-1:0]    card_addr, ram_addr;
  logic [DW-1:0]    card_wdata, ram_wdata, ram_rdata;
  logic             ram_en, ram_we;

  assign host_acc  = dat_wr || dat_rd;
  assign card_gnt  = card_req && !host_acc;
  assign ram_en    = host_acc || card_gnt;
  assign ram_we    = host_acc ? dat_wr : card_we;
  assign ram_addr  = host_acc ? {buf_sel, word_off} : card_addr;
  assign ram_wdata = host_acc ? dat_wdata : card_wdata;
  assign rd_data   = ram_rdata;

  dbp_index #(.OFF_W(OFF_W), .BUF_W(BUF_W), .AINC_BIT(AINC_BIT), .IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata), .step(host_acc),
    .buf_sel(buf_sel), .word_off(word_off), .idx_q(idx_q));

  dbp_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata));

  dbp_card #(.OFF_W(OFF_W), .BUF_W(BUF_W), .DW(DW), .BYTES_W(BYTES_W)) u_card (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir(xfer_dir), .xfer_buf(xfer_buf),
    .xfer_bytes(xfer_bytes), .busy(xfer_busy), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_data(fill_data), .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_data(drain_data), .mem_req(card_req), .mem_we(card_we), .mem_addr(card_addr),
    .mem_wdata(card_wdata), .mem_gnt(card_gnt), .mem_rdata(ram_rdata), .buf_done(buf_done),
    .done_buf(done_buf), .done_type(done_type));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= dat_rd && !dat_wr;
  end

  // R10: during a host access the RAM address follows the host index
  assert_host_owns_ram_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc |-> (ram_en && ram_addr == {buf_sel, word_off}));

  // R3: read data is flagged only after a host read
  assert_rd_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(dat_rd));
endmodule

// File: tb/test_xfer_buf_port.sv
`timescale 1ns/1ps
module test_xfer_buf_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [16:0] idx_wdata = '0;
  logic [16:0] idx_q;
  logic        dat_wr = 1'b0;
  logic [63:0] dat_wdata = '0;
  logic        dat_rd = 1'b0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        xfer_start = 1'b0;
  logic        xfer_dir = 1'b0;
  logic [0:0]  xfer_buf = '0;
  logic [9:0]  xfer_bytes = '0;
  logic        xfer_busy;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [7:0]  fill_data = '0;
  logic        drain_valid;
  logic        drain_ready = 1'b0;
  logic [7:0]  drain_data;
  logic        buf_done;
  logic [0:0]  done_buf;
  logic [1:0]  done_type;

  always #4 clk = ~clk;

  xfer_buf_port i_xfer_buf_port (.*);

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [63:0] mem [2][64];
  logic [16:0] m_idx;
  logic        m_rdv;
  logic [63:0] m_rdd;
  bit          m_busy, m_dir;
  int          m_buf, m_ptr, m_left, m_lane;
  logic [63:0] m_asm;
  logic [7:0]  expq[$];
  logic        s_v, s_r;
  logic [7:0]  s_d;

  always @(posedge clk) begin
    cyc++;
    s_v = drain_valid; s_r = drain_ready; s_d = drain_data;
    if (!rst_n) begin
      m_idx = '0; m_rdv = 0; m_busy = 0; m_lane = 0;
      for (int b = 0; b < 2; b++) for (int w = 0; w < 64; w++) mem[b][w] = '0;
    end else begin
      int ab, ao, nw;
      ab = int'(m_idx[6]); ao = int'(m_idx[5:0]);
      m_rdv = dat_rd && !dat_wr;
      if (m_rdv) m_rdd = mem[ab][ao];
      if (dat_wr) mem[ab][ao] = dat_wdata;
      if (idx_wr) m_idx = idx_wdata;
      else if ((dat_wr || dat_rd) && m_idx[16]) m_idx[5:0] = m_idx[5:0] + 6'd1;
      nw = int'(xfer_bytes) / 8;
      if (xfer_start && !m_busy && nw != 0 && nw <= 64 && xfer_bytes[2:0] == 3'd0) begin
        m_busy = 1; m_dir = xfer_dir; m_buf = int'(xfer_buf); m_ptr = 64 - nw;
        m_left = nw; m_lane = 0;
        if (m_dir) begin
          for (int w = m_ptr; w < 64; w++)
            for (int k = 0; k < 8; k++) expq.push_back(mem[m_buf][w][63-8*k -: 8]);
        end
      end
      if (fill_valid && fill_ready) begin
        m_asm[63-8*m_lane -: 8] = fill_data;
        m_lane++;
        if (m_lane == 8) begin
          mem[m_buf][m_ptr] = m_asm; m_ptr++; m_lane = 0; m_left--;
          if (m_left == 0) m_busy = 0;
        end
      end
      if (drain_valid && drain_ready) begin
        if (expq.size() == 0) chk("R9 drain byte beyond length", 64'(drain_data), 64'hx);
        else chk("R9 drain byte order", 64'(drain_data), 64'(expq.pop_front()));
        if (expq.size() == 0 && m_dir) m_busy = 0;
      end
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 R4 index register", 64'(idx_q), 64'(m_idx));
      chk("R3 rd_valid", 64'(rd_valid), 64'(m_rdv));
      if (m_rdv) chk("R3 rd_data", rd_data, m_rdd);
      if (s_v && !s_r) chk("R9 stalled drain byte held", {55'd0, drain_valid, drain_data}, {55'd0, 1'b1, s_d});
    end
  end

  always @(negedge clk) drain_ready <= (cyc % 3) != 2;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected<%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic host_op(input logic iw, input logic [16:0] iv, input logic w,
                         input logic [63:0] wd, input logic r);
    @(negedge clk);
    idx_wr = iw; idx_wdata = iv; dat_wr = w; dat_wdata = wd; dat_rd = r;
  endtask

  task automatic idle();
    host_op(1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic read_expect(input string tag, input logic [63:0] exp);
    host_op(1'b0, '0, 1'b0, '0, 1'b1);
    idle();
    chk(tag, rd_data, exp);
  endtask

  task automatic xfer(input logic d, input logic b, input int n);
    @(negedge clk);
    xfer_start = 1'b1; xfer_dir = d; xfer_buf = b; xfer_bytes = 10'(n);
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic fill_send(input logic [7:0] v);
    @(negedge clk);
    fill_valid = 1'b1; fill_data = v;
    while (!fill_ready) @(negedge clk);
  endtask

  task automatic wait_done(input string tag, input int eb, input int et);
    int n = 0;
    while (!buf_done && n < 2000) begin @(negedge clk); n++; end
    chk({tag, " done pulse"}, 64'(buf_done), 64'd1);
    chk({tag, " done_buf"}, 64'(done_buf), 64'(eb));
    chk({tag, " done_type"}, 64'(done_type), 64'(et));
  endtask

  logic [63:0] expw;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idx_q", 64'(idx_q), 64'd0);
    chk("R1 outputs", {58'd0, rd_valid, xfer_busy, fill_ready, drain_valid, buf_done, 1'b0},
        64'd0);
    chk("R1 done_type", 64'(done_type), 64'd0);
    rst_n = 1'b1;

    // R4 stepped sweep with wrap, buffer 0
    host_op(1'b1, 17'h10000, 1'b0, '0, 1'b0);
    for (int i = 0; i < 64; i++) host_op(1'b0, '0, 1'b1, {32'hA5C3_0000 + 32'(i), ~32'(i)}, 1'b0);
    idle();
    chk("R4 offset wrapped to 0 in same buffer", 64'(idx_q), 64'h10000);
    for (int i = 0; i < 64; i++) host_op(1'b0, '0, 1'b0, '0, 1'b1);
    idle();
    read_expect("R3 word 0 after wrap", {32'hA5C3_0000, ~32'd0});

    // R5 fixed index repeats, buffer 1 separate
    host_op(1'b1, 17'h10045, 1'b0, '0, 1'b0);
    for (int i = 0; i < 3; i++) host_op(1'b0, '0, 1'b1, 64'h1111_0000_0000_0000 + 64'(i), 1'b0);
    host_op(1'b1, 17'h00007, 1'b0, '0, 1'b0);
    for (int i = 0; i < 3; i++) host_op(1'b0, '0, 1'b0, '0, 1'b1);
    idle();
    chk("R5 index unchanged by reads", 64'(idx_q), 64'h7);
    host_op(1'b0, '0, 1'b1, 64'hDEAD_0001, 1'b0);
    host_op(1'b0, '0, 1'b1, 64'hDEAD_0002, 1'b0);
    idle();
    read_expect("R5 second write hit same word", 64'hDEAD_0002);
    host_op(1'b1, 17'h00046, 1'b0, '0, 1'b0);
    read_expect("R2 buffer 1 word 6", 64'h1111_0000_0000_0001);

    // R6 index write together with a read
    host_op(1'b1, 17'h10002, 1'b0, '0, 1'b0);
    host_op(1'b1, 17'h10028, 1'b0, '0, 1'b1);
    idle();
    chk("R6 read used old index", rd_data, {32'hA5C3_0002, ~32'd2});
    chk("R6 new index loaded without step", 64'(idx_q), 64'h10028);

    // R8 full-length fill into buffer 1
    xfer(1'b0, 1'b1, 512);
    for (int i = 0; i < 512; i++) fill_send(8'(i * 7 + 3));
    @(negedge clk); fill_valid = 1'b0;
    wait_done("R11 fill 512", 1, 1);
    for (int k = 0; k < 8; k++) expw[63-8*k -: 8] = 8'(k * 7 + 3);
    host_op(1'b1, 17'h10040, 1'b0, '0, 1'b0);
    read_expect("R8 packed word 0 of buffer 1", expw);
    for (int i = 0; i < 63; i++) host_op(1'b0, '0, 1'b0, '0, 1'b1);
    idle();

    // R7 short fill lands at the end of buffer 0
    xfer(1'b0, 1'b0, 16);
    for (int i = 0; i < 16; i++) fill_send(8'(8'hC0 + i));
    @(negedge clk); fill_valid = 1'b0;
    wait_done("R11 fill 16", 0, 1);
    host_op(1'b1, 17'h1003D, 1'b0, '0, 1'b0);
    read_expect("R7 word 61 untouched", {32'hA5C3_003D, ~32'd61});
    read_expect("R7 R8 word 62", 64'hC0C1_C2C3_C4C5_C6C7);
    read_expect("R7 R8 word 63", 64'hC8C9_CACB_CCCD_CECF);

    // R9 drain of 4 words under back-pressure
    xfer(1'b1, 1'b0, 32);
    wait_done("R11 drain 32", 0, 2);
    repeat (2) @(negedge clk);
    chk("R9 all drain bytes delivered", 64'(expq.size()), 64'd0);

    // R10 host reads hold off a pending card word
    host_op(1'b1, 17'h10000, 1'b0, '0, 1'b0);
    idle();
    xfer(1'b0, 1'b1, 8);
    for (int i = 0; i < 8; i++) fill_send(8'(8'h50 + i));
    @(negedge clk);
    fill_valid = 1'b0; dat_rd = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 no completion while host owns RAM", 64'(buf_done), 64'd0);
    end
    dat_rd = 1'b0;
    wait_done("R10 R11 fill after host release", 1, 1);
    host_op(1'b1, 17'h0007F, 1'b0, '0, 1'b0);
    read_expect("R10 deferred word stored", 64'h5051_5253_5455_5657);

    // R7 starts ignored while busy or with bad length
    xfer(1'b0, 1'b1, 16);
    xfer(1'b1, 1'b0, 8);
    for (int i = 0; i < 16; i++) fill_send(8'(i));
    @(negedge clk); fill_valid = 1'b0;
    wait_done("R7 busy start ignored", 1, 1);
    repeat (3) @(negedge clk);
    chk("R7 no drain from ignored start", {62'd0, xfer_busy, drain_valid}, 64'd0);
    xfer(1'b0, 1'b0, 0);
    chk("R7 zero length ignored", 64'(xfer_busy), 64'd0);
    xfer(1'b0, 1'b0, 12);
    chk("R7 non-multiple length ignored", 64'(xfer_busy), 64'd0);
    xfer(1'b0, 1'b0, 520);
    chk("R7 oversize length ignored", 64'(xfer_busy), 64'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule